// File: doc/BRIEF.md
# Tag-Renaming Reservation Station Cluster

This block holds a small pool of reservation stations that serve one class of functional unit. It also holds a register status table that renames each destination to the tag of the station that will produce it, and one shared result bus. An operation arrives with an opcode, a destination register and two source register numbers. Each source is taken as a value when the register holds one. If the register is still waiting on a station, the source is taken as that station's tag instead.

A station stays parked and watches the result bus until both operands are values. It then offers its opcode and operands on its own dispatch lane to an external execution unit. Later it takes back a result on its own completion lane. Completed stations compete for the result bus. The bus carries the result together with the tag of the station that produced it. Every waiting station and every register entry compares that tag with its own pending tags. Because consumers hold tags rather than register names, a later writer of a register may finish first without harming an earlier reader. A stale broadcast also never overwrites a newer rename.

Top module: `rsv_cluster`

## Requirements
- R1: An operation is accepted only while at least one station is free. `iss_ready` is low exactly when all `NUM_RS` stations are occupied. An accepted operation takes the lowest-index free station, and `iss_tag` shows that station's tag, which is its index plus one.
- R2: On acceptance, the destination register's tag becomes the new station's tag, visible on `rd_tag` from the following cycle. Sources are looked up before this rename, so a source equal to the destination reads the older state.
- R3: A station raises its `disp_valid` bit for exactly one cycle, and only once both operands are values. The earliest such cycle is the one after acceptance. The dispatched opcode equals the accepted `iss_op` code (0 add, 1 subtract, 2 and, 3 xor, carried through unchanged).
- R4: While a station waits, a bus broadcast whose tag equals a pending source tag replaces that source with the broadcast value. The dispatched operands therefore equal the source values that in-order execution would have read.
- R5: A dispatched station accepts its `ex_done` bit together with its slice of `ex_result`. It then drives that value on `cdb_data` with its tag on `cdb_tag`, and it is free again after the clock edge that ends the broadcast cycle. `cdb_valid` stays low when no station holds a finished result.
- R6: A register whose tag equals the broadcast tag takes the broadcast value and returns to tag 0. If the same register is renamed in that cycle, the new tag wins.
- R7: A register whose tag differs from the broadcast tag keeps both its value and its tag. An older producer's late result never overwrites a newer rename.
- R8: If the result bus carries the tag of a pending source in the very cycle that source is issued, the bus value is captured directly. The station can then dispatch in the next cycle.
- R9: At most one result is broadcast per cycle. When several stations hold finished results, the lowest-index one is granted and the others keep their results until granted.
- R10: After reset every station is free, `iss_ready` is high, `cdb_valid` and all `disp_valid` bits are low, and register k holds value k with tag 0.
- R11: A later operation that writes a register still needed by an earlier waiting station may complete first. The earlier station still dispatches the value of its original producer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| iss_valid | input | 1 | Operation offered for issue |
| iss_op | input | OP_W | Opcode carried to the station |
| iss_dst | input | REG_W | Destination register |
| iss_src1 | input | REG_W | First source register |
| iss_src2 | input | REG_W | Second source register |
| iss_ready | output | 1 | A station is free this cycle |
| iss_tag | output | TAG_W | Tag that an accepted operation receives |
| disp_valid | output | NUM_RS | Per-station dispatch pulse |
| disp_op | output | NUM_RS*OP_W | Per-station dispatched opcode |
| disp_a | output | NUM_RS*DATA_W | Per-station first operand |
| disp_b | output | NUM_RS*DATA_W | Per-station second operand |
| ex_done | input | NUM_RS | Per-station completion strobe |
| ex_result | input | NUM_RS*DATA_W | Per-station completion value |
| cdb_valid | output | 1 | Result bus carries a result |
| cdb_tag | output | TAG_W | Tag of the producing station |
| cdb_data | output | DATA_W | Broadcast result |
| rd_addr | input | REG_W | Register status read address |
| rd_value | output | DATA_W | Value held for that register |
| rd_tag | output | TAG_W | Pending tag of that register, 0 when the value is current |

## Verification
Corrupted operand state in a station appears on its dispatch lane as soon as that station dispatches. The bench compares every dispatched operand with the value that in-order execution would have read. A wrong tag in the register table appears one or two cycles later. It shows either as a consumer that never dispatches, which stalls the drain, or as a final register value that differs from the in-order result. Arbitration faults appear on the very broadcast cycle, because the bench predicts which tag owns the bus from the completions it has driven itself.

// File: rtl/rsv_pkg.sv
package rsv_pkg;

    parameter int NUM_RS   = 4;
    parameter int NUM_REGS = 8;
    parameter int DATA_W   = 16;

    localparam int TAG_W = $clog2(NUM_RS + 1);
    localparam int REG_W = $clog2(NUM_REGS);
    localparam int OP_W  = 2;

    typedef logic [DATA_W-1:0] data_t;
    typedef logic [TAG_W-1:0]  tag_t;
    typedef logic [REG_W-1:0]  ridx_t;

    typedef enum logic [OP_W-1:0] {
        OP_ADD = 2'd0,
        OP_SUB = 2'd1,
        OP_AND = 2'd2,
        OP_XOR = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        ST_FREE = 2'd0,
        ST_WAIT = 2'd1,
        ST_EXEC = 2'd2,
        ST_DONE = 2'd3
    } st_e;

    localparam tag_t NO_TAG = '0;

    // result bus: value plus producer tag
    typedef struct packed {
        logic  valid;
        tag_t  tag;
        data_t data;
    } bus_t;

    // one operand: value valid when tag is zero
    typedef struct packed {
        data_t val;
        tag_t  tag;
    } src_t;

    typedef struct packed {
        op_e  op;
        src_t j;
        src_t k;
    } slot_t;

    function automatic tag_t tag_of(input int idx);
        return tag_t'(idx + 1);
    endfunction

    // replace a pending operand by the bus value on tag match
    function automatic src_t snoop(input src_t s, input bus_t bus);
        src_t o;
        o = s;
        if (s.tag != NO_TAG && bus.valid && bus.tag == s.tag) begin
            o.val = bus.data;
            o.tag = NO_TAG;
        end
        return o;
    endfunction

endpackage

// File: rtl/rsv_alloc.sv
module rsv_alloc
    import rsv_pkg::*;
(
    input  logic [NUM_RS-1:0] busy,
    output logic              ready,
    output logic [NUM_RS-1:0] pick,
    output tag_t              tag
);

    always_comb begin
        pick = '0;
        tag  = NO_TAG;
        for (int i = 0; i < NUM_RS; i++) begin
            if (!busy[i] && pick == '0) begin
                pick[i] = 1'b1;
                tag     = tag_of(i);
            end
        end
    end

    assign ready = ~&busy;

endmodule

// File: rtl/rsv_station.sv
module rsv_station
    import rsv_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  alloc,
    input  slot_t alloc_slot,
    input  bus_t  bus,
    input  logic  grant,
    input  logic  ex_done,
    input  data_t ex_res,
    output logic  busy,
    output logic  disp_valid,
    output slot_t disp_slot,
    output logic  done_req,
    output data_t done_data
);

    st_e   state;
    slot_t slot;
    data_t res;
    logic  ops_ready;

    assign ops_ready  = (slot.j.tag == NO_TAG) && (slot.k.tag == NO_TAG);
    assign busy       = (state != ST_FREE);
    assign disp_valid = (state == ST_WAIT) && ops_ready;
    assign disp_slot  = slot;
    assign done_req   = (state == ST_DONE);
    assign done_data  = res;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_FREE;
            slot  <= '0;
            res   <= '0;
        end else begin
            case (state)
                ST_FREE: begin
                    if (alloc) begin
                        state <= ST_WAIT;
                        slot  <= alloc_slot;
                    end
                end
                ST_WAIT: begin
                    if (ops_ready) begin
                        state <= ST_EXEC;
                    end else begin
                        slot.j <= snoop(slot.j, bus);
                        slot.k <= snoop(slot.k, bus);
                    end
                end
                ST_EXEC: begin
                    if (ex_done) begin
                        res   <= ex_res;
                        state <= ST_DONE;
                    end
                end
                ST_DONE: begin
                    if (grant) state <= ST_FREE;
                end
                default: state <= ST_FREE;
            endcase
        end
    end

    // R1: the allocator never targets an occupied station
    p_alloc_free_r1: assert property (@(posedge clk) disable iff (rst)
        alloc |-> state == ST_FREE);

    // R4: a matching broadcast fills a waiting first operand
    p_snoop_j_r4: assert property (@(posedge clk) disable iff (rst)
        (state == ST_WAIT && bus.valid && slot.j.tag != NO_TAG && slot.j.tag == bus.tag)
        |=> (slot.j.tag == NO_TAG && slot.j.val == $past(bus.data)));

    p_snoop_k_r4: assert property (@(posedge clk) disable iff (rst)
        (state == ST_WAIT && bus.valid && slot.k.tag != NO_TAG && slot.k.tag == bus.tag)
        |=> (slot.k.tag == NO_TAG && slot.k.val == $past(bus.data)));

    // R3: dispatch is a single-cycle pulse
    p_disp_once_r3: assert property (@(posedge clk) disable iff (rst)
        disp_valid |=> !disp_valid);

    // R9: only a station holding a result is granted the bus
    p_grant_done_r9: assert property (@(posedge clk) disable iff (rst)
        grant |-> state == ST_DONE);

endmodule

// File: rtl/rsv_regstat.sv
module rsv_regstat
    import rsv_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  ren_we,
    input  ridx_t ren_dst,
    input  tag_t  ren_tag,
    input  bus_t  bus,
    input  ridx_t ra_a,
    input  ridx_t ra_b,
    input  ridx_t ra_c,
    output src_t  rd_a,
    output src_t  rd_b,
    output src_t  rd_c
);

    data_t val_q [NUM_REGS];
    tag_t  tag_q [NUM_REGS];

    always_ff @(posedge clk) begin
        for (int r = 0; r < NUM_REGS; r++) begin
            if (rst) begin
                val_q[r] <= data_t'(r);
                tag_q[r] <= NO_TAG;
            end else begin
                if (bus.valid && tag_q[r] != NO_TAG && tag_q[r] == bus.tag) begin
                    val_q[r] <= bus.data;
                    tag_q[r] <= NO_TAG;
                end
                // a rename in the same cycle overrides the clear
                if (ren_we && ren_dst == ridx_t'(r)) tag_q[r] <= ren_tag;
            end
        end
    end

    always_comb begin
        rd_a.val = val_q[ra_a];
        rd_a.tag = tag_q[ra_a];
        rd_b.val = val_q[ra_b];
        rd_b.tag = tag_q[ra_b];
        rd_c.val = val_q[ra_c];
        rd_c.tag = tag_q[ra_c];
    end

    for (genvar r = 0; r < NUM_REGS; r++) begin : g_chk
        // R2: a rename installs the issuing tag
        p_rename_r2: assert property (@(posedge clk) disable iff (rst)
            (ren_we && ren_dst == ridx_t'(r)) |=> tag_q[r] == $past(ren_tag));

        // R6: matching broadcast writes the value and clears the tag
        p_capture_r6: assert property (@(posedge clk) disable iff (rst)
            (bus.valid && bus.tag != NO_TAG && tag_q[r] == bus.tag &&
             !(ren_we && ren_dst == ridx_t'(r)))
            |=> (tag_q[r] == NO_TAG && val_q[r] == $past(bus.data)));

        // R7: a non-matching broadcast leaves the entry alone
        p_keep_r7: assert property (@(posedge clk) disable iff (rst)
            (bus.valid && tag_q[r] != bus.tag && !(ren_we && ren_dst == ridx_t'(r)))
            |=> ($stable(val_q[r]) && $stable(tag_q[r])));
    end

endmodule

// File: rtl/rsv_bus_arb.sv
module rsv_bus_arb
    import rsv_pkg::*;
(
    input  logic                           clk,
    input  logic                           rst,
    input  logic [NUM_RS-1:0]              req,
    input  logic [NUM_RS-1:0][DATA_W-1:0]  req_data,
    output logic [NUM_RS-1:0]              grant,
    output bus_t                           bus
);

    always_comb begin
        grant = '0;
        bus   = '0;
        for (int i = 0; i < NUM_RS; i++) begin
            if (req[i] && grant == '0) begin
                grant[i]  = 1'b1;
                bus.valid = 1'b1;
                bus.tag   = tag_of(i);
                bus.data  = req_data[i];
            end
        end
    end

    // R9: a single owner per cycle
    p_one_owner_r9: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant));

    for (genvar i = 0; i < NUM_RS; i++) begin : g_pri
        localparam logic [NUM_RS-1:0] LOWER = NUM_RS'((1 << i) - 1);

        // R9: no lower-index requester is passed over
        p_lowest_r9: assert property (@(posedge clk) disable iff (rst)
            grant[i] |-> (req & LOWER) == '0);

        // R9: a losing requester keeps its result
        p_hold_r9: assert property (@(posedge clk) disable iff (rst)
            (req[i] && !grant[i]) |=> req[i]);
    end

endmodule

// File: rtl/rsv_cluster.sv
module rsv_cluster
    import rsv_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       iss_valid,
    input  logic [OP_W-1:0]            iss_op,
    input  logic [REG_W-1:0]           iss_dst,
    input  logic [REG_W-1:0]           iss_src1,
    input  logic [REG_W-1:0]           iss_src2,
    output logic                       iss_ready,
    output logic [TAG_W-1:0]           iss_tag,
    output logic [NUM_RS-1:0]          disp_valid,
    output logic [NUM_RS*OP_W-1:0]     disp_op,
    output logic [NUM_RS*DATA_W-1:0]   disp_a,
    output logic [NUM_RS*DATA_W-1:0]   disp_b,
    input  logic [NUM_RS-1:0]          ex_done,
    input  logic [NUM_RS*DATA_W-1:0]   ex_result,
    output logic                       cdb_valid,
    output logic [TAG_W-1:0]           cdb_tag,
    output logic [DATA_W-1:0]          cdb_data,
    input  logic [REG_W-1:0]           rd_addr,
    output logic [DATA_W-1:0]          rd_value,
    output logic [TAG_W-1:0]           rd_tag
);

    logic [NUM_RS-1:0]             busy;
    logic [NUM_RS-1:0]             pick;
    logic [NUM_RS-1:0]             grant;
    logic [NUM_RS-1:0]             done_req;
    logic [NUM_RS-1:0][DATA_W-1:0] done_data;
    slot_t                         disp_slot [NUM_RS];
    bus_t                          bus;
    src_t                          src_a, src_b, src_rd;
    slot_t                         new_slot;
    logic                          accept;

    rsv_alloc u_alloc (
        .busy  (busy),
        .ready (iss_ready),
        .pick  (pick),
        .tag   (iss_tag)
    );

    assign accept = iss_valid && iss_ready;

    rsv_regstat u_regs (
        .clk     (clk),
        .rst     (rst),
        .ren_we  (accept),
        .ren_dst (iss_dst),
        .ren_tag (iss_tag),
        .bus     (bus),
        .ra_a    (iss_src1),
        .ra_b    (iss_src2),
        .ra_c    (rd_addr),
        .rd_a    (src_a),
        .rd_b    (src_b),
        .rd_c    (src_rd)
    );

    // sources see a broadcast landing in the issue cycle
    always_comb begin
        new_slot.op = op_e'(iss_op);
        new_slot.j  = snoop(src_a, bus);
        new_slot.k  = snoop(src_b, bus);
    end

    for (genvar i = 0; i < NUM_RS; i++) begin : g_rs
        rsv_station u_st (
            .clk        (clk),
            .rst        (rst),
            .alloc      (accept && pick[i]),
            .alloc_slot (new_slot),
            .bus        (bus),
            .grant      (grant[i]),
            .ex_done    (ex_done[i]),
            .ex_res     (ex_result[i*DATA_W +: DATA_W]),
            .busy       (busy[i]),
            .disp_valid (disp_valid[i]),
            .disp_slot  (disp_slot[i]),
            .done_req   (done_req[i]),
            .done_data  (done_data[i])
        );
        assign disp_op[i*OP_W +: OP_W]     = disp_slot[i].op;
        assign disp_a[i*DATA_W +: DATA_W]  = disp_slot[i].j.val;
        assign disp_b[i*DATA_W +: DATA_W]  = disp_slot[i].k.val;
    end

    rsv_bus_arb u_arb (
        .clk      (clk),
        .rst      (rst),
        .req      (done_req),
        .req_data (done_data),
        .grant    (grant),
        .bus      (bus)
    );

    assign cdb_valid = bus.valid;
    assign cdb_tag   = bus.tag;
    assign cdb_data  = bus.data;
    assign rd_value  = src_rd.val;
    assign rd_tag    = src_rd.tag;

    // R1: ready drops only with every station occupied
    p_full_stall_r1: assert property (@(posedge clk) disable iff (rst)
        !iss_ready |-> $countones(busy) == NUM_RS);

    // R5: the broadcasting station is free after the broadcast
    p_free_after_bus_r5: assert property (@(posedge clk) disable iff (rst)
        cdb_valid |=> (busy & $past(grant)) == '0);

endmodule

// File: tb/tb_rsv_cluster.sv
module tb_rsv_cluster;
    import rsv_pkg::*;

    localparam int NRS = NUM_RS;
    localparam int NR  = NUM_REGS;
    localparam int DW  = DATA_W;

    logic                   clk = 1'b0;
    logic                   rst = 1'b1;
    logic                   iss_valid;
    logic [OP_W-1:0]        iss_op;
    logic [REG_W-1:0]       iss_dst, iss_src1, iss_src2;
    logic                   iss_ready;
    logic [TAG_W-1:0]       iss_tag;
    logic [NRS-1:0]         disp_valid;
    logic [NRS*OP_W-1:0]    disp_op;
    logic [NRS*DW-1:0]      disp_a, disp_b;
    logic [NRS-1:0]         ex_done;
    logic [NRS*DW-1:0]      ex_result;
    logic                   cdb_valid;
    logic [TAG_W-1:0]       cdb_tag;
    logic [DW-1:0]          cdb_data;
    logic [REG_W-1:0]       rd_addr;
    logic [DW-1:0]          rd_value;
    logic [TAG_W-1:0]       rd_tag;

    always #10 clk = ~clk;

    rsv_cluster dut (.*);

    int n_tests = 0;
    int n_fail  = 0;

    logic [DW-1:0]   ref_reg [NR];
    logic [OP_W-1:0] e_op  [NRS];
    logic [DW-1:0]   e_a   [NRS];
    logic [DW-1:0]   e_b   [NRS];
    logic [DW-1:0]   e_res [NRS];
    int              cnt   [NRS];
    logic [NRS-1:0]  bmask = '0, freeing = '0, pend = '0, drove_last = '0, dseen = '0;
    int              lat_force = 0;
    bit              saw_clash = 0;

    function automatic logic [DW-1:0] model(input int op, input logic [DW-1:0] a, input logic [DW-1:0] b);
        case (op)
            0: return a + b;
            1: return a - b;
            2: return a & b;
            default: return a ^ b;
        endcase
    endfunction

    function automatic int lowest(input logic [NRS-1:0] m);
        for (int i = 0; i < NRS; i++) if (m[i]) return i;
        return -1;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // execution unit model, bus prediction and dispatch checking
    always @(negedge clk) begin
        logic [NRS-1:0] drove;
        int lo;
        if (!rst) begin
            bmask   = bmask & ~freeing;
            freeing = '0;
            pend    = pend | drove_last;
            if ($countones(pend) > 1) saw_clash = 1;
            if (pend != '0) begin
                lo = lowest(pend);
                check(cdb_valid, "R9", "bus valid with finished station", cdb_valid, 1);
                check(cdb_tag == TAG_W'(lo + 1), "R9", "lowest finished owns bus", cdb_tag, lo + 1);
                check(cdb_data == e_res[lo], "R5", "broadcast value", cdb_data, e_res[lo]);
                pend[lo]    = 1'b0;
                freeing[lo] = 1'b1;
                dseen[lo]   = 1'b0;
            end else begin
                check(!cdb_valid, "R5", "bus idle without result", cdb_valid, 0);
            end
            drove = '0;
            ex_done = '0;
            for (int i = 0; i < NRS; i++) begin
                if (cnt[i] > 0) begin
                    cnt[i]--;
                    if (cnt[i] == 0) begin
                        ex_done[i] = 1'b1;
                        ex_result[i*DW +: DW] = e_res[i];
                        drove[i] = 1'b1;
                    end
                end
            end
            drove_last = drove;
            for (int i = 0; i < NRS; i++) begin
                if (disp_valid[i]) begin
                    check(bmask[i] && !dseen[i], "R3", "single dispatch of issued station", dseen[i], 0);
                    check(disp_op[i*OP_W +: OP_W] == e_op[i], "R3", "dispatched opcode",
                          disp_op[i*OP_W +: OP_W], e_op[i]);
                    check(disp_a[i*DW +: DW] == e_a[i], "R4", "first operand", disp_a[i*DW +: DW], e_a[i]);
                    check(disp_b[i*DW +: DW] == e_b[i], "R4", "second operand", disp_b[i*DW +: DW], e_b[i]);
                    dseen[i] = 1'b1;
                    cnt[i] = (lat_force > 0) ? lat_force : 1 + int'($urandom % 4);
                end
            end
        end
    end

    task automatic drive_issue(input int op, input int dst, input int s1, input int s2,
                               output bit acc, output int tg);
        int lo;
        #2;
        iss_valid = 1'b1;
        iss_op    = OP_W'(op);
        iss_dst   = REG_W'(dst);
        iss_src1  = REG_W'(s1);
        iss_src2  = REG_W'(s2);
        #1;
        acc = iss_ready;
        tg  = 0;
        if (&bmask) begin
            check(!iss_ready, "R1", "ready with all stations occupied", iss_ready, 0);
        end else begin
            lo = lowest(~bmask);
            check(iss_ready && iss_tag == TAG_W'(lo + 1), "R1", "lowest free tag", iss_tag, lo + 1);
            if (iss_ready) begin
                tg        = lo + 1;
                e_op[lo]  = OP_W'(op);
                e_a[lo]   = ref_reg[s1];
                e_b[lo]   = ref_reg[s2];
                e_res[lo] = model(op, ref_reg[s1], ref_reg[s2]);
                ref_reg[dst] = e_res[lo];
                bmask[lo] = 1'b1;
            end
        end
        @(posedge clk);
        #1;
        iss_valid = 1'b0;
        rd_addr = REG_W'(dst);
        #1;
        if (acc) check(rd_tag == TAG_W'(tg), "R2", "destination renamed", rd_tag, tg);
    endtask

    task automatic issue(input int op, input int dst, input int s1, input int s2, output int tg);
        bit acc;
        do begin
            @(negedge clk);
            drive_issue(op, dst, s1, s2, acc, tg);
        end while (!acc);
    endtask

    task automatic drain();
        int guard = 0;
        do begin
            @(negedge clk);
            guard++;
        end while ((bmask != '0 || pend != '0 || drove_last != '0) && guard < 1000);
        check(bmask == '0, "R5", "all stations freed after drain", bmask, 0);
        @(negedge clk);
    endtask

    task automatic check_reg(input int r, input string req);
        #3;
        rd_addr = REG_W'(r);
        #1;
        check(rd_tag == NO_TAG, req, "register tag settled", rd_tag, 0);
        check(rd_value == ref_reg[r], req, "register value", rd_value, ref_reg[r]);
    endtask

    initial begin
        int tg, tp, tq;
        bit acc;
        void'($urandom(32'd20240611));
        iss_valid = 0; iss_op = '0; iss_dst = '0; iss_src1 = '0; iss_src2 = '0;
        ex_done = '0; ex_result = '0; rd_addr = '0;
        for (int r = 0; r < NR; r++) ref_reg[r] = DW'(r);
        for (int i = 0; i < NRS; i++) begin
            cnt[i] = 0; e_op[i] = '0; e_a[i] = '0; e_b[i] = '0; e_res[i] = '0;
        end
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R10: reset state
        @(negedge clk);
        check(iss_ready, "R10", "ready after reset", iss_ready, 1);
        check(!cdb_valid, "R10", "bus idle after reset", cdb_valid, 0);
        check(disp_valid == '0, "R10", "no dispatch after reset", disp_valid, 0);
        for (int r = 0; r < NR; r++) check_reg(r, "R10");

        // R11 and R7: later writer of r6 finishes before the old producer
        lat_force = 15;
        issue(0, 6, 1, 2, tp);
        issue(1, 7, 6, 0, tg);
        lat_force = 1;
        issue(3, 6, 3, 4, tg);
        drain();
        check_reg(6, "R7");
        check_reg(7, "R11");

        // R1: fill every station, then try one more
        lat_force = 25;
        for (int i = 0; i < NRS; i++) issue(0, i, 4 + i, 5, tg);
        @(negedge clk);
        drive_issue(1, 7, 1, 2, acc, tg);
        check(!acc, "R1", "issue refused while full", acc, 0);
        drain();
        for (int r = 0; r < NR; r++) check_reg(r, "R6");

        // R9: two consumers of one producer finish together
        saw_clash = 0;
        lat_force = 2;
        issue(0, 1, 2, 3, tp);
        issue(0, 4, 1, 5, tg);
        issue(3, 5, 1, 6, tg);
        drain();
        check(saw_clash, "R9", "simultaneous finish arbitrated", saw_clash, 1);
        check_reg(4, "R9");
        check_reg(5, "R9");

        // R8: issue a consumer in the producer's broadcast cycle
        lat_force = 3;
        issue(0, 2, 3, 4, tp);
        for (int g = 0; g < 40; g++) begin
            @(negedge clk);
            if (cdb_valid && cdb_tag == TAG_W'(tp)) break;
        end
        check(cdb_valid && cdb_tag == TAG_W'(tp), "R8", "producer broadcast seen", cdb_tag, tp);
        drive_issue(1, 5, 2, 2, acc, tq);
        @(negedge clk);
        check(acc && tq > 0 && disp_valid[(tq > 0 ? tq : 1) - 1], "R8",
              "consumer dispatches the cycle after issue", disp_valid, tq);
        drain();
        check_reg(5, "R8");

        // random mix
        lat_force = 0;
        for (int n = 0; n < 400; n++) begin
            issue(int'($urandom % 4), int'($urandom % NR), int'($urandom % NR), int'($urandom % NR), tg);
            repeat (int'($urandom % 3)) @(negedge clk);
        end
        drain();
        for (int r = 0; r < NR; r++) check_reg(r, "R6");

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        n_tests++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 150000, 0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule